// File: doc/BRIEF.md
# Fractional Clock Divider with Commit Trigger

This block divides its input clock by a programmable divisor that carries both an integer and a fractional part. Software writes a new divider field into a holding register. That write alone changes nothing. The new value is applied only after software sets a commit bit, and software can poll that bit to learn when the change has landed. The fractional part is realised by a phase accumulator. The accumulator stretches some output periods by one input cycle, so that the long-run average period equals the programmed divisor.

The field is stored in offset form. Its low `FRAC_W` bits are the fraction of the divisor. The bits above them hold the integer part minus one, so the offset of one lands at bit `FRAC_W` and never at bit 0. A gate enable from the upstream clock gate pauses the divider. While the gate is off, the counter freezes, the output is held low and a pending commit waits.

Top module: `frac_clkdiv`

## Requirements
- R1: While reset is asserted and after its release, all readable registers read 0, the commit bit reads 0 and `div_clk` is 0. The active field of 0 means divisor 1.0.
- R2: The field is `INT_W+FRAC_W` bits wide and sits at address 0 (holding value) and at address 2 (active value, read-only). The scaled divisor is field + 2^FRAC_W, and the divisor is the scaled divisor divided by 2^FRAC_W.
- R3: Each output period lasts floor(scaled/2^FRAC_W) input cycles, plus one when adding the field's fractional bits to a FRAC_W-bit accumulator carries out. Any 2^FRAC_W consecutive periods therefore total exactly the scaled divisor in cycles.
- R4: Within a period of length L, `div_clk` is high for the first ceil(L/2) cycles and low for the rest. At L = 1 it stays high.
- R5: A write with data bit 0 set to address 1 sets the commit bit. The bit reads back as 1 at bit 0 of address 1 from the next cycle on.
- R6: A pending commit copies the holding field into the active field at the next period boundary. That period is already timed with the new value, and the commit bit clears at the same edge.
- R7: Writing the holding field without a commit leaves the active field and the output unchanged.
- R8: While `gate_en` is low, the period counter and the active field hold, `div_clk` is 0, and a set commit bit stays set until the gate reopens and the commit completes.
- R9: Writes to address 2 or address 3, and writes of 0 to the commit bit, change no register. Address 3 reads 0.
- R10: If the holding field is rewritten while a commit is pending, the most recently written value is the one that is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Clock enable from the gate; low pauses the divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 holding field, 1 commit bit |
| wr_data | input | INT_W+FRAC_W | Write data |
| rd_addr | input | 2 | Read address: 0 holding, 1 commit bit, 2 active field |
| rd_data | output | INT_W+FRAC_W | Read data, combinational from the address |
| div_clk | output | 1 | Divided clock, registered |

## Verification
A register write is visible on `rd_data` right after the clock edge that captures it. The commit bit therefore reads 1 from the cycle after the trigger write. The active field and the new period length change at the period-boundary edge that follows, and `div_clk` is registered, so it reflects each edge's decision in the cycle after that edge. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It compares `div_clk` and the addressed register one time unit after every rising edge. Period lengths are measured as the distance between rising edges of `div_clk`, and their sums over full accumulator cycles are checked against the scaled divisor.

// File: rtl/frac_clkdiv_pkg.sv
package frac_clkdiv_pkg;

    // Register addresses seen on the write/read port
    typedef enum logic [1:0] {
        ADDR_HOLD   = 2'd0,
        ADDR_COMMIT = 2'd1,
        ADDR_ACTIVE = 2'd2,
        ADDR_SPARE  = 2'd3
    } fdiv_addr_e;

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
    import frac_clkdiv_pkg::*;
#(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [INT_W+FRAC_W-1:0] wr_data,
    input  logic [1:0]              rd_addr,
    output logic [INT_W+FRAC_W-1:0] rd_data,
    input  logic                    boundary,
    output logic [INT_W+FRAC_W-1:0] upcoming_field,
    output logic [INT_W+FRAC_W-1:0] active_field,
    output logic                    busy
);
    localparam int FW = INT_W + FRAC_W;

    typedef struct packed {
        logic [FW-1:0] hold;
        logic [FW-1:0] active;
        logic          pend;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // the commit lands on a period boundary and uses the value held before this edge
        if (boundary && r_q.pend) begin
            r_d.active = r_q.hold;
            r_d.pend   = 1'b0;
        end
        if (wr_en) begin
            case (fdiv_addr_e'(wr_addr))
                ADDR_HOLD:   r_d.hold = wr_data;
                ADDR_COMMIT: if (wr_data[0]) r_d.pend = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (fdiv_addr_e'(rd_addr))
            ADDR_HOLD:   rd_data = r_q.hold;
            ADDR_COMMIT: rd_data = FW'(r_q.pend);
            ADDR_ACTIVE: rd_data = r_q.active;
            default:     rd_data = '0;
        endcase
    end

    assign upcoming_field = r_q.pend ? r_q.hold : r_q.active;
    assign active_field   = r_q.active;
    assign busy           = r_q.pend;

endmodule

// File: rtl/fdiv_frac_acc.sv
module fdiv_frac_acc #(
    parameter int FRAC_W = 3,
    localparam int AW    = (FRAC_W > 0) ? FRAC_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [AW-1:0] frac_in,
    output logic          carry
);
    generate
        if (FRAC_W > 0) begin : g_acc
            logic [FRAC_W-1:0] acc_d, acc_q;
            logic [FRAC_W:0]   sum;

            always_comb begin
                sum   = {1'b0, acc_q} + {1'b0, frac_in};
                acc_d = advance ? sum[FRAC_W-1:0] : acc_q;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= acc_d;
            end

            assign carry = sum[FRAC_W];
        end else begin : g_int_only
            assign carry = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fdiv_phase.sv
module fdiv_phase #(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 3,
    localparam int FW    = INT_W + FRAC_W,
    localparam int CNT_W = INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [FW-1:0]    next_field,
    output logic             boundary,
    output logic             div_clk,
    output logic [CNT_W-1:0] count
);
    localparam int SCW = FW + 1;
    localparam int AW  = (FRAC_W > 0) ? FRAC_W : 1;
    localparam logic [SCW-1:0] ONE_SCALED = SCW'(1) << FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic             out;
    } phase_t;

    phase_t p_d, p_q;

    logic [SCW-1:0]   scaled;
    logic [CNT_W-1:0] whole;
    logic [CNT_W-1:0] len;
    logic [AW-1:0]    frac_bits;
    logic             carry;

    generate
        if (FRAC_W > 0) begin : g_frac
            assign frac_bits = next_field[FRAC_W-1:0];
        end else begin : g_nofrac
            assign frac_bits = '0;
        end
    endgenerate

    assign boundary = run && (p_q.cnt == CNT_W'(1));

    fdiv_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (boundary),
        .frac_in (frac_bits),
        .carry   (carry)
    );

    always_comb begin
        scaled = {1'b0, next_field} + ONE_SCALED;
        whole  = scaled[SCW-1:FRAC_W];
        len    = whole + CNT_W'(carry);
        p_d    = p_q;
        if (run) begin
            if (boundary) begin
                p_d.cnt  = len;
                p_d.half = len >> 1;
            end else begin
                p_d.cnt = p_q.cnt - CNT_W'(1);
            end
            p_d.out = (p_d.cnt > p_d.half);
        end else begin
            p_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cnt  <= CNT_W'(1);
            p_q.half <= '0;
            p_q.out  <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign div_clk = p_q.out;
    assign count   = p_q.cnt;

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv #(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gate_en,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [INT_W+FRAC_W-1:0] wr_data,
    input  logic [1:0]              rd_addr,
    output logic [INT_W+FRAC_W-1:0] rd_data,
    output logic                    div_clk
);
    localparam int FW    = INT_W + FRAC_W;
    localparam int CNT_W = INT_W + 1;

    logic             boundary;
    logic             busy;
    logic [FW-1:0]    upcoming_field;
    logic [FW-1:0]    active_field;
    logic [CNT_W-1:0] count;

    fdiv_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .boundary       (boundary),
        .upcoming_field (upcoming_field),
        .active_field   (active_field),
        .busy           (busy)
    );

    fdiv_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (gate_en),
        .next_field (upcoming_field),
        .boundary   (boundary),
        .div_clk    (div_clk),
        .count      (count)
    );

endmodule

// File: rtl/frac_clkdiv_chk.sv
module frac_clkdiv_chk #(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    gate_en,
    input logic                    div_clk,
    input logic                    busy,
    input logic                    boundary,
    input logic [INT_W+FRAC_W-1:0] active_field,
    input logic [INT_W:0]          count
);
    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && count > (INT_W+1)'(1)) |=> count == (INT_W+1)'($past(count) - 1'b1));

    assert_gate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> !div_clk);

    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> ($stable(active_field) && $stable(count)));

    assert_commit_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_field) |-> $past(busy));

    assert_pend_clears_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(boundary));

endmodule

bind frac_clkdiv frac_clkdiv_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_en      (gate_en),
    .div_clk      (div_clk),
    .busy         (busy),
    .boundary     (boundary),
    .active_field (active_field),
    .count        (count)
);

// File: tb/frac_clkdiv_test.sv
`timescale 1ns/1ps
module frac_clkdiv_test;
    localparam int INT_W  = 6;
    localparam int FRAC_W = 3;
    localparam int FW     = INT_W + FRAC_W;
    localparam int ONE    = 1 << FRAC_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [FW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = 2'd0;
    logic [FW-1:0] rd_data;
    logic          div_clk;

    frac_clkdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .div_clk(div_clk)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    // behavioural reference
    int m_hold, m_active, m_pend, m_cnt, m_half, m_acc, m_clk;
    int m_f, m_sc, m_s, m_len;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_hold = 0; m_active = 0; m_pend = 0;
            m_cnt = 1; m_half = 0; m_acc = 0; m_clk = 0;
        end else begin
            if (gate_en) begin
                if (m_cnt == 1) begin
                    m_f   = (m_pend != 0) ? m_hold : m_active;
                    m_sc  = m_f + ONE;
                    m_s   = m_acc + (m_sc % ONE);
                    m_len = m_sc / ONE + m_s / ONE;
                    m_acc = m_s % ONE;
                    m_cnt = m_len;
                    m_half = m_len / 2;
                    if (m_pend != 0) begin
                        m_active = m_hold;
                        m_pend = 0;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                end
                m_clk = (m_cnt > m_half) ? 1 : 0;
            end else begin
                m_clk = 0;
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) m_hold = int'(wr_data);
                else if (wr_addr == 2'd1 && wr_data[0]) m_pend = 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R4 div_clk waveform", int'(div_clk), m_clk);
            case (rd_addr)
                2'd0: check("R2 holding field readback", int'(rd_data), m_hold);
                2'd1: check("R5 commit bit readback", int'(rd_data), m_pend);
                2'd2: check("R6 active field readback", int'(rd_data), m_active);
                default: check("R9 spare address reads 0", int'(rd_data), 0);
            endcase
        end
    end

    // rising-edge recorder for period lengths
    bit   rec = 0;
    logic prev_clk = 1'b0;
    int   edges[$];
    always @(posedge clk) begin
        #1;
        if (rec && div_clk && !prev_clk) edges.push_back(cyc);
        prev_clk = div_clk;
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_addr = rd_addr + 2'd1;
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = FW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_now(input logic [1:0] a, output int v);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: state during reset
        read_now(2'd0, v); check("R1 holding field in reset", v, 0);
        read_now(2'd1, v); check("R1 commit bit in reset", v, 0);
        read_now(2'd2, v); check("R1 active field in reset", v, 0);
        check("R1 div_clk in reset", int'(div_clk), 0);
        @(negedge clk); rst_n = 1'b1;
        tick(2);
        check("R1 div_clk low with gate off", int'(div_clk), 0);

        gate_en = 1'b1;
        tick(8);
        check("R4 divide by one stays high", int'(div_clk), 1);

        // R7: holding write alone does nothing
        write_reg(2'd0, 12);          // 2.5
        tick(6);
        @(negedge clk);
        read_now(2'd2, v); check("R7 active unchanged without commit", v, 0);
        read_now(2'd0, v); check("R2 holding field value", v, 12);
        check("R7 output unchanged without commit", int'(div_clk), 1);

        // R5 / R6: commit
        write_reg(2'd1, 1);
        read_now(2'd1, v); check("R5 commit bit set after trigger", v, 1);
        tick(4);
        @(negedge clk);
        read_now(2'd2, v); check("R6 active field after commit", v, 12);
        read_now(2'd1, v); check("R6 commit bit cleared", v, 0);

        // R3: 2.5 gives periods 2 and 3 alternating
        edges.delete();
        rec = 1; tick(40); rec = 0;
        for (int i = 0; i + 2 < edges.size() && i < 6; i++) begin
            check("R3 two periods of divisor 2.5 span 5 cycles",
                  edges[i+2] - edges[i], 5);
        end

        // R8: gate off keeps commit pending
        @(negedge clk); gate_en = 1'b0;
        write_reg(2'd0, 16);
        write_reg(2'd1, 1);
        tick(20);
        @(negedge clk);
        read_now(2'd1, v); check("R8 commit pending while gated", v, 1);
        read_now(2'd2, v); check("R8 active held while gated", v, 12);
        check("R8 div_clk low while gated", int'(div_clk), 0);

        // R10: newest holding value wins
        write_reg(2'd0, 40);          // 6.0
        @(negedge clk); gate_en = 1'b1;
        tick(10);
        @(negedge clk);
        read_now(2'd2, v); check("R10 latest holding value committed", v, 40);
        read_now(2'd1, v); check("R8 commit completes after gate reopens", v, 0);

        // R9: ignored writes
        write_reg(2'd2, 5);
        write_reg(2'd3, 7);
        write_reg(2'd1, 0);
        tick(2);
        @(negedge clk);
        read_now(2'd2, v); check("R9 active unaffected by writes", v, 40);
        read_now(2'd0, v); check("R9 holding unaffected by other addresses", v, 40);
        read_now(2'd1, v); check("R9 zero write leaves commit clear", v, 0);
        read_now(2'd3, v); check("R9 spare address reads 0", v, 0);

        // R3: 2.625, eight periods total 21 cycles
        write_reg(2'd0, 13);
        write_reg(2'd1, 1);
        tick(10);
        edges.delete();
        rec = 1; tick(120); rec = 0;
        for (int i = 0; i + 8 < edges.size() && i < 4; i++) begin
            check("R3 eight periods of divisor 2.625 span 21 cycles",
                  edges[i+8] - edges[i], 21);
        end

        // R2: largest field, 64.875
        write_reg(2'd0, (1 << FW) - 1);
        write_reg(2'd1, 1);
        tick(80);
        edges.delete();
        rec = 1; tick(600); rec = 0;
        for (int i = 0; i + 8 < edges.size() && i < 1; i++) begin
            check("R2 R3 eight periods of largest divisor span 519 cycles",
                  edges[i+8] - edges[i], 519);
        end

        // back to divide by one
        write_reg(2'd0, 0);
        write_reg(2'd1, 1);
        tick(80);
        check("R4 divide by one restored", int'(div_clk), 1);

        finished = 1;
        summary();
    end

endmodule